// File: doc/BRIEF.md
# Shadowed Memory Transfer Engine

This block owns a small volatile working array and a nonvolatile-style shadow array of the same size. A host reads and writes the working array through a simple synchronous port. Two bulk transfers move the whole contents between the arrays. A save copies the working array into the shadow. A restore copies the shadow back into the working array. Each transfer is started by a one-cycle strobe and walks the arrays one word per clock.

A save runs in two phases. It first wipes every shadow word to zero, then programs every shadow word from the working array. A restore also runs in two phases. It first zeroes every working word, then loads every working word from the shadow. A restore never writes the shadow, so it can be repeated any number of times.

Each transfer keeps the engine busy for a fixed, parameterised number of cycles, even when the walk finishes sooner. During that time the host port is locked out. A one-cycle done pulse follows.

The controller is a state machine with these states: `SX_IDLE`, `SX_ERASE`, `SX_PROG`, `SX_CLEAR`, `SX_LOAD`, `SX_HOLD` and `SX_DONE`. Its transitions are:
- A save strobe moves `SX_IDLE` to `SX_ERASE`.
- A restore strobe moves `SX_IDLE` to `SX_CLEAR`.
- On the last word, `SX_ERASE` moves to `SX_PROG` and `SX_CLEAR` moves to `SX_LOAD`.
- On the last word, `SX_PROG` and `SX_LOAD` both move to `SX_HOLD`.
- Any busy state moves to `SX_DONE` on the final cycle of the operation time.
- `SX_DONE` always returns to `SX_IDLE`.

Top module: `shadow_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `port_off` and `host_rvalid` are 0, and every working word reads as 0.
- R2: While the engine is not busy, a host write stores `host_wdata` at `host_addr`. A host read (`host_en`=1, `host_we`=0) returns the word on `host_rdata`, with `host_rvalid`=1, in the following cycle.
- R3: A save strobe accepted in idle makes `busy` high from the next cycle for exactly `STORE_CYCLES` cycles. The cycle after that has `done`=1 and `busy`=0, and `done` is low again one cycle later. The duration is clamped to at least 2*DEPTH.
- R4: A restore strobe accepted in idle makes `busy` high for exactly `RECALL_CYCLES` cycles, followed by a one-cycle `done`. The duration is clamped to at least 2*DEPTH.
- R5: While busy, `port_off` is 1. A host read issued in a busy cycle gives `host_rvalid`=0 and `host_rdata`=0, and host writes leave the working array unchanged.
- R6: A save or restore strobe that arrives while busy is ignored. It neither lengthens the current operation nor starts a new one after `done`.
- R7: A save erases the shadow before programming it. After a save and a restore, the working array holds exactly the words present at the save, with no bits left over from an earlier save.
- R8: A restore zeroes the working array and then loads it from the shadow. Host writes made after the last save do not survive a restore.
- R9: A restore never modifies the shadow. Repeated restores, each preceded by host overwrites, return the same contents.
- R10: When both strobes are high in the same idle cycle, the save wins: the busy time is the save duration and the shadow is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_go | input | 1 | Save strobe: copy the working array into the shadow |
| recall_go | input | 1 | Restore strobe: copy the shadow into the working array |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host word address |
| host_wdata | input | WIDTH | Host write data |
| host_rdata | output | WIDTH | Host read data, registered; 0 when not valid |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after a transfer ends |
| port_off | output | 1 | Host port is locked out |

## Verification
The controller's state is visible at the ports mainly through the length of the `busy` window. That window is counted against the expected duration, so a wrong counter, a wrong duration select or a premature `SX_DONE` shows up on the very `done` cycle. Errors in the walk, such as a skipped phase, a bad index or a wrong write source, only appear at the next restore, when every word is read back and compared with a bench model. The save-then-restore round trip with a pattern that has fewer ones than the previous save exposes a missing erase. Lockout faults appear one cycle after a read or write attempted during `busy`.

// File: rtl/sxe_pkg.sv
package sxe_pkg;

    typedef enum logic [2:0] {
        SX_IDLE  = 3'd0,
        SX_ERASE = 3'd1,
        SX_PROG  = 3'd2,
        SX_CLEAR = 3'd3,
        SX_LOAD  = 3'd4,
        SX_HOLD  = 3'd5,
        SX_DONE  = 3'd6
    } sx_state_t;

    // Effective busy length: never shorter than the two-phase walk.
    function automatic int sxe_len(input int cycles, input int depth);
        return (cycles < 2 * depth) ? 2 * depth : cycles;
    endfunction

endpackage

// File: rtl/sxe_word_array.sv
module sxe_word_array #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int NRD   = 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/sxe_ctrl.sv
module sxe_ctrl
    import sxe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int S_LEN = 400,
    parameter int R_LEN = 40,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_go,
    input  logic          recall_go,
    output sx_state_t     state,
    output logic [AW-1:0] idx,
    output logic          busy,
    output logic          done,
    output logic          sh_we,
    output logic          sh_prog,
    output logic          wk_we,
    output logic          wk_load
);

    localparam int MAXL = (S_LEN > R_LEN) ? S_LEN : R_LEN;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] S_LAST = CW'(S_LEN - 1);
    localparam logic [CW-1:0] R_LAST = CW'(R_LEN - 1);
    localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

    sx_state_t     nxt;
    logic [CW-1:0] cnt;
    logic          op_store;
    logic          walking;
    logic          idx_last;
    logic          time_up;

    assign idx_last = (idx == IDX_LAST);
    assign time_up  = busy && (cnt == (op_store ? S_LAST : R_LAST));

    // State register, duration counter and walk index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            op_store <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SX_IDLE) begin
                cnt      <= '0;
                idx      <= '0;
                op_store <= store_go;
            end else begin
                cnt <= cnt + 1'b1;
                if (walking) begin
                    idx <= idx_last ? '0 : idx + 1'b1;
                end
            end
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            SX_IDLE: begin
                if (store_go)       nxt = SX_ERASE;
                else if (recall_go) nxt = SX_CLEAR;
            end
            SX_ERASE: if (idx_last) nxt = SX_PROG;
            SX_PROG:  if (idx_last) nxt = SX_HOLD;
            SX_CLEAR: if (idx_last) nxt = SX_LOAD;
            SX_LOAD:  if (idx_last) nxt = SX_HOLD;
            SX_HOLD:  nxt = SX_HOLD;
            SX_DONE:  nxt = SX_IDLE;
            default:  nxt = SX_IDLE;
        endcase
        if (time_up) nxt = SX_DONE;
    end

    // Output decode.
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        sh_we   = 1'b0;
        sh_prog = 1'b0;
        wk_we   = 1'b0;
        wk_load = 1'b0;
        walking = 1'b0;
        unique case (state)
            SX_IDLE:  ;
            SX_ERASE: begin busy = 1'b1; sh_we = 1'b1; walking = 1'b1; end
            SX_PROG:  begin busy = 1'b1; sh_we = 1'b1; sh_prog = 1'b1; walking = 1'b1; end
            SX_CLEAR: begin busy = 1'b1; wk_we = 1'b1; walking = 1'b1; end
            SX_LOAD:  begin busy = 1'b1; wk_we = 1'b1; wk_load = 1'b1; walking = 1'b1; end
            SX_HOLD:  busy = 1'b1;
            SX_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/shadow_xfer_engine.sv
module shadow_xfer_engine
    import sxe_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter int DEPTH         = 16,
    parameter int STORE_CYCLES  = 400,
    parameter int RECALL_CYCLES = 40,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_go,
    input  logic             recall_go,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    output logic             host_rvalid,
    output logic             busy,
    output logic             done,
    output logic             port_off
);

    localparam int S_LEN = sxe_len(STORE_CYCLES, DEPTH);
    localparam int R_LEN = sxe_len(RECALL_CYCLES, DEPTH);

    sx_state_t            state;
    logic [AW-1:0]        idx;
    logic                 sh_we, sh_prog, wk_walk_we, wk_load;
    logic                 in_recall;
    logic                 host_rd, host_wr;
    logic                 wk_we;
    logic [AW-1:0]        wk_waddr;
    logic [WIDTH-1:0]     wk_wdata;
    logic [1:0][AW-1:0]   wk_raddr;
    logic [1:0][WIDTH-1:0] wk_rdata;
    logic [0:0][AW-1:0]   sh_raddr;
    logic [0:0][WIDTH-1:0] sh_rdata;
    logic [WIDTH-1:0]     sh_wdata;

    sxe_ctrl #(.DEPTH(DEPTH), .S_LEN(S_LEN), .R_LEN(R_LEN), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .store_go (store_go),
        .recall_go(recall_go),
        .state    (state),
        .idx      (idx),
        .busy     (busy),
        .done     (done),
        .sh_we    (sh_we),
        .sh_prog  (sh_prog),
        .wk_we    (wk_walk_we),
        .wk_load  (wk_load)
    );

    assign port_off  = busy;
    assign in_recall = (state == SX_CLEAR) || (state == SX_LOAD);
    assign host_rd   = host_en && !host_we && !busy;
    assign host_wr   = host_en &&  host_we && !busy;

    // Working array: walk port has priority, host port only when idle.
    assign wk_we       = wk_walk_we || host_wr;
    assign wk_waddr    = wk_walk_we ? idx : host_addr;
    assign wk_wdata    = wk_walk_we ? (wk_load ? sh_rdata[0] : '0) : host_wdata;
    assign wk_raddr[0] = host_addr;
    assign wk_raddr[1] = idx;

    sxe_word_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(2), .AW(AW)) u_work (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wk_we),
        .waddr(wk_waddr),
        .wdata(wk_wdata),
        .raddr(wk_raddr),
        .rdata(wk_rdata)
    );

    // Shadow array: erase writes zero, program writes the working word.
    assign sh_wdata    = sh_prog ? wk_rdata[1] : '0;
    assign sh_raddr[0] = idx;

    sxe_word_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(1), .AW(AW)) u_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (sh_we),
        .waddr(idx),
        .wdata(sh_wdata),
        .raddr(sh_raddr),
        .rdata(sh_rdata)
    );

    // Registered host read path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd;
            host_rdata  <= host_rd ? wk_rdata[0] : '0;
        end
    end

endmodule

// File: rtl/sxe_checker.sv
module sxe_checker #(
    parameter int S_LEN = 400,
    parameter int R_LEN = 40
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic port_off,
    input logic host_rvalid,
    input logic sh_we,
    input logic wk_walk_we,
    input logic in_recall
);

    localparam int MAXL = (S_LEN > R_LEN) ? S_LEN : R_LEN;
    localparam int CW   = $clog2(MAXL + 2);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == CW'(S_LEN) || run == CW'(R_LEN)));

    assert_done_follows_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_read_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_off |=> !host_rvalid);

    assert_shadow_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_recall |-> !sh_we);

    assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_we && wk_walk_we));

    assert_restart_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind shadow_xfer_engine sxe_checker #(.S_LEN(S_LEN), .R_LEN(R_LEN)) u_sxe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .port_off   (port_off),
    .host_rvalid(host_rvalid),
    .sh_we      (sh_we),
    .wk_walk_we (wk_walk_we),
    .in_recall  (in_recall)
);

// File: tb/tb_shadow_xfer_engine.sv
module tb_shadow_xfer_engine;

    localparam int WIDTH = 8;
    localparam int DEPTH = 16;
    localparam int SCYC  = 400;
    localparam int RCYC  = 40;
    localparam int AW    = $clog2(DEPTH);
    localparam int S_EXP = (SCYC < 2 * DEPTH) ? 2 * DEPTH : SCYC;
    localparam int R_EXP = (RCYC < 2 * DEPTH) ? 2 * DEPTH : RCYC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             store_go = 1'b0, recall_go = 1'b0;
    logic             host_en = 1'b0, host_we = 1'b0;
    logic [AW-1:0]    host_addr = '0;
    logic [WIDTH-1:0] host_wdata = '0;
    logic [WIDTH-1:0] host_rdata;
    logic             host_rvalid, busy, done, port_off;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] m_work [DEPTH];
    logic [WIDTH-1:0] m_shadow [DEPTH];

    always #2 clk = ~clk;

    shadow_xfer_engine #(.WIDTH(WIDTH), .DEPTH(DEPTH),
                         .STORE_CYCLES(SCYC), .RECALL_CYCLES(RCYC)) dut (
        .clk(clk), .rst_n(rst_n), .store_go(store_go), .recall_go(recall_go),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .busy(busy), .done(done), .port_off(port_off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        m_work[a] = d;
    endtask

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_en = 1'b0;
        chk({tag, " rvalid"}, 32'(host_rvalid), 32'd1);
        chk({tag, " rdata"},  32'(host_rdata),  32'(m_work[a]));
    endtask

    task automatic fill_random();
        for (int a = 0; a < DEPTH; a++) wr(a, WIDTH'($urandom));
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < DEPTH; a++) rd_chk(a, tag);
    endtask

    // mode: 0 = restore, 1 = save, 2 = both strobes together
    task automatic run_op(input int mode, input string tag);
        int n;
        int exp_len;
        exp_len = (mode == 0) ? R_EXP : S_EXP;
        @(negedge clk);
        store_go  = (mode != 0);
        recall_go = (mode != 1);
        @(negedge clk);
        store_go = 1'b0; recall_go = 1'b0;
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            if (n == 2) chk({tag, " R5 port_off"}, 32'(port_off), 32'd1);
            if (n == 4) begin
                chk({tag, " R5 locked rvalid"}, 32'(host_rvalid), 32'd0);
                chk({tag, " R5 locked rdata"},  32'(host_rdata),  32'd0);
            end
            chk({tag, " done low while busy"}, 32'(done), 32'd0);
            host_en    = (n == 3) || (n == 4);
            host_we    = (n == 4);
            host_addr  = '0;
            host_wdata = 8'hA5;
            store_go   = (n == 5);   // R6: ignored strobes
            recall_go  = (n == 6);
            @(negedge clk);
        end
        host_en = 1'b0; host_we = 1'b0; store_go = 1'b0; recall_go = 1'b0;
        chk({tag, " busy length"}, 32'(n), 32'(exp_len));
        chk({tag, " done pulse"}, 32'(done), 32'd1);
        @(negedge clk);
        chk({tag, " R6 done cleared"}, 32'(done), 32'd0);
        chk({tag, " R6 no restart"}, 32'(busy), 32'd0);
        if (mode == 0) begin
            for (int a = 0; a < DEPTH; a++) m_work[a] = m_shadow[a];
        end else begin
            for (int a = 0; a < DEPTH; a++) m_shadow[a] = m_work[a];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) begin
            m_work[a] = '0; m_shadow[a] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 port_off", 32'(port_off), 32'd0);
        chk("R1 rvalid", 32'(host_rvalid), 32'd0);
        read_all("R1 zero array");

        // R2: host write and read while idle
        fill_random();
        read_all("R2 readback");
        wr(DEPTH - 1, 8'hFF);
        rd_chk(DEPTH - 1, "R2 top address");
        wr(0, 8'h00);
        rd_chk(0, "R2 zero word");

        // R3: save
        run_op(1, "R3 save");
        read_all("R5 writes ignored during save");

        // R8: overwrite, restore, expect saved contents
        fill_random();
        run_op(0, "R4 restore");
        read_all("R8 restored contents");

        // R9: repeated restore returns the same data
        fill_random();
        run_op(0, "R9 restore again");
        read_all("R9 shadow unchanged");

        // R7: new save with fewer ones must not keep old bits
        for (int a = 0; a < DEPTH; a++) wr(a, m_work[a] & WIDTH'($urandom));
        wr(1, 8'h00);
        run_op(1, "R7 save subset");
        for (int a = 0; a < DEPTH; a++) wr(a, 8'hFF);
        run_op(0, "R7 restore");
        read_all("R7 exact after erase");

        // R10: both strobes together, save wins
        fill_random();
        run_op(2, "R10 both strobes");
        fill_random();
        run_op(0, "R10 restore");
        read_all("R10 save took effect");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule